// File: doc/BRIEF.md
# Embedded-Sync Video Stream Decoder

This block watches a byte-wide multiplexed 4:2:2 component video stream, one byte per cycle of the double-rate pixel clock, with samples in the order Cb, Y, Cr, Y. It recovers all line and field timing from the timing reference codes embedded in the stream itself. A code is three preamble bytes (all-ones, all-zeros, all-zeros) followed by a status byte that carries the field, vertical-blank and horizontal flags.

From these codes the block keeps the three decoded flags, a field output and a blanking output. It also produces a one-clock strobe at the start of each active line. A demultiplexer splits the bytes of the active region into separate luma and chroma sample outputs, each with its own valid pulse and a tag that tells Cb from Cr. A clock-enable input qualifies every byte, so the stream can arrive with gaps. The low status bits, which carry error-protection information, are not used.

Top module: `vid_sync_decoder`

## Requirements
- R1: After reset, blank is 1 and f_flag, v_flag, h_flag, field, sav_strobe, y_valid and c_valid are all 0.
- R2: A code is accepted when the enabled bytes 0xFF, 0x00, 0x00 are followed by an enabled status byte whose bit 7 is 1. From the clock after the status byte, f_flag, v_flag and h_flag equal its bits 6, 5 and 4 (F=1 second field, V=1 vertical blanking, H=1 end of active video, H=0 start of active video).
- R3: Status bits 3 to 0 have no effect on any output.
- R4: A preamble that breaks off (0xFF not followed by 0x00, 0x00, or a status byte with bit 7 = 0) leaves every flag unchanged and returns the detector to idle. A further 0xFF starts a new preamble, so 0xFF 0xFF 0x00 0x00 status is accepted.
- R5: An accepted code with H=1 sets blank to 1. An accepted code with H=0 sets blank to its V bit. While v_flag is 1, blank is 1.
- R6: sav_strobe is 1 for exactly the one clock after an accepted code with H=0 and V=0, and 0 otherwise.
- R7: field takes the F bit of each accepted code with H=1. Codes with H=0 leave field unchanged.
- R8: While blank is 0, the enabled bytes other than 0x00 and 0xFF are split in the order Cb, Y, Cr, Y. The byte after a start-of-active code is Cb. Each chroma byte appears on c_data with a one-clock c_valid pulse and c_is_cr = 1 for Cr. Each luma byte appears on y_data with a one-clock y_valid pulse. Both appear one clock after the byte is on the bus.
- R9: Preamble bytes (0x00, 0xFF) and status bytes are never emitted as samples and do not advance the Cb/Y/Cr/Y order. While blank is 1, no sample is emitted.
- R10: A byte presented with ce = 0 changes no state and produces no valid pulse or strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Byte qualifier; the byte on din is used only when high |
| din | input | 8 | Multiplexed video byte stream |
| f_flag | output | 1 | F bit of the last accepted code |
| v_flag | output | 1 | V bit of the last accepted code |
| h_flag | output | 1 | H bit of the last accepted code |
| blank | output | 1 | High outside the active picture |
| sav_strobe | output | 1 | One-clock pulse at the start of an active line |
| field | output | 1 | Field taken from end-of-active codes |
| y_data | output | 8 | Last luma sample |
| y_valid | output | 1 | Pulse: y_data holds a new sample |
| c_data | output | 8 | Last chroma sample |
| c_valid | output | 1 | Pulse: c_data holds a new sample |
| c_is_cr | output | 1 | With c_valid: 1 for Cr, 0 for Cb |

## Verification
The hardest case to reach is the interplay between the preamble detector and sample separation. This covers a preamble that breaks off after one or two bytes, a repeated 0xFF, and a status byte with its top bit clear, all arriving while the flags hold known values. It also covers enable gaps that fall in the middle of an active line. The stimulus sweeps sixteen lines through every F/V combination, with varying protection nibbles, active lengths and enable gaps. Some start-of-active codes carry a deliberately mismatched F bit to show that only end-of-active codes move the field output. A final run feeds hand-built broken preambles and a full code held under ce = 0, and checks that every flag stays put.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    typedef enum logic [1:0] {
        SEEK_IDLE,
        SEEK_ONES,
        SEEK_ZERO1,
        SEEK_ZERO2
    } seek_state_e;

    typedef struct packed {
        seek_state_e state;
    } seek_regs_t;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
        logic blank;
        logic field;
        logic sav;
    } flag_regs_t;

    typedef struct packed {
        logic [1:0] phase;
        logic [7:0] y;
        logic       yv;
        logic [7:0] c;
        logic       cv;
        logic       cr;
    } split_regs_t;

endpackage

// File: rtl/vsd_code_seek.sv
module vsd_code_seek
    import vsd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic [DW-1:0] din,
    output logic          code_ok,
    output logic          code_f,
    output logic          code_v,
    output logic          code_h,
    output logic          in_seq
);
    localparam logic [DW-1:0] ONES = {DW{1'b1}};
    localparam logic [DW-1:0] ZERO = {DW{1'b0}};

    seek_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        code_ok = 1'b0;
        if (ce) begin
            case (r_q.state)
                SEEK_IDLE: begin
                    if (din == ONES) r_d.state = SEEK_ONES;
                end
                SEEK_ONES: begin
                    if (din == ZERO)      r_d.state = SEEK_ZERO1;
                    else if (din == ONES) r_d.state = SEEK_ONES;
                    else                  r_d.state = SEEK_IDLE;
                end
                SEEK_ZERO1: begin
                    if (din == ZERO)      r_d.state = SEEK_ZERO2;
                    else if (din == ONES) r_d.state = SEEK_ONES;
                    else                  r_d.state = SEEK_IDLE;
                end
                SEEK_ZERO2: begin
                    r_d.state = SEEK_IDLE;
                    code_ok   = din[DW-1];
                end
                default: r_d.state = SEEK_IDLE;
            endcase
        end
    end

    assign code_f = din[DW-2];
    assign code_v = din[DW-3];
    assign code_h = din[DW-4];
    assign in_seq = (r_q.state != SEEK_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: SEEK_IDLE};
        else        r_q <= r_d;
    end

    AST_ACCEPT_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        code_ok |-> ce); // R10
    AST_ACCEPT_AFTER_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        code_ok |-> (in_seq && $past(ce))); // R2

endmodule

// File: rtl/vsd_flags.sv
module vsd_flags
    import vsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic code_ok,
    input  logic code_f,
    input  logic code_v,
    input  logic code_h,
    output logic f_flag,
    output logic v_flag,
    output logic h_flag,
    output logic blank,
    output logic field,
    output logic sav_strobe
);
    flag_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.sav = 1'b0;
        if (code_ok) begin
            r_d.f = code_f;
            r_d.v = code_v;
            r_d.h = code_h;
            if (code_h) begin
                r_d.blank = 1'b1;
                r_d.field = code_f;
            end else begin
                r_d.blank = code_v;
                r_d.sav   = !code_v;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{f: 1'b0, v: 1'b0, h: 1'b0, blank: 1'b1,
                             field: 1'b0, sav: 1'b0};
        else        r_q <= r_d;
    end

    assign f_flag     = r_q.f;
    assign v_flag     = r_q.v;
    assign h_flag     = r_q.h;
    assign blank      = r_q.blank;
    assign field      = r_q.field;
    assign sav_strobe = r_q.sav;

    AST_SAV_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        sav_strobe |=> !sav_strobe); // R6
    AST_BLANK_IN_VBI: assert property (@(posedge clk) disable iff (!rst_n)
        v_flag |-> blank); // R5
    AST_SAV_OPENS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        sav_strobe |-> (!blank && !h_flag && !v_flag)); // R6

endmodule

// File: rtl/vsd_splitter.sv
module vsd_splitter
    import vsd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic [DW-1:0] din,
    input  logic          blank,
    input  logic          in_seq,
    input  logic          line_start,
    output logic [DW-1:0] y_data,
    output logic          y_valid,
    output logic [DW-1:0] c_data,
    output logic          c_valid,
    output logic          c_is_cr
);
    localparam logic [DW-1:0] ONES = {DW{1'b1}};
    localparam logic [DW-1:0] ZERO = {DW{1'b0}};

    split_regs_t r_d, r_q;
    logic        take;

    assign take = ce && !blank && !in_seq && (din != ZERO) && (din != ONES);

    always_comb begin
        r_d    = r_q;
        r_d.yv = 1'b0;
        r_d.cv = 1'b0;
        if (line_start) begin
            r_d.phase = 2'd0;
        end else if (take) begin
            if (r_q.phase[0]) begin
                r_d.y  = din;
                r_d.yv = 1'b1;
            end else begin
                r_d.c  = din;
                r_d.cv = 1'b1;
                r_d.cr = r_q.phase[1];
            end
            r_d.phase = r_q.phase + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign y_data  = r_q.y;
    assign y_valid = r_q.yv;
    assign c_data  = r_q.c;
    assign c_valid = r_q.cv;
    assign c_is_cr = r_q.cr;

    AST_ONE_SAMPLE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(y_valid && c_valid)); // R8
    AST_SAMPLE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (y_valid || c_valid) |-> $past(ce)); // R10
    AST_NO_SAMPLE_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (y_valid || c_valid) |-> !$past(blank)); // R9

endmodule

// File: rtl/vid_sync_decoder.sv
module vid_sync_decoder
    import vsd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic [DW-1:0] din,
    output logic          f_flag,
    output logic          v_flag,
    output logic          h_flag,
    output logic          blank,
    output logic          sav_strobe,
    output logic          field,
    output logic [DW-1:0] y_data,
    output logic          y_valid,
    output logic [DW-1:0] c_data,
    output logic          c_valid,
    output logic          c_is_cr
);
    logic code_ok, code_f, code_v, code_h, in_seq;

    vsd_code_seek #(.DW(DW)) u_seek (
        .clk(clk), .rst_n(rst_n), .ce(ce), .din(din),
        .code_ok(code_ok), .code_f(code_f), .code_v(code_v),
        .code_h(code_h), .in_seq(in_seq)
    );

    vsd_flags u_flags (
        .clk(clk), .rst_n(rst_n), .code_ok(code_ok),
        .code_f(code_f), .code_v(code_v), .code_h(code_h),
        .f_flag(f_flag), .v_flag(v_flag), .h_flag(h_flag),
        .blank(blank), .field(field), .sav_strobe(sav_strobe)
    );

    vsd_splitter #(.DW(DW)) u_split (
        .clk(clk), .rst_n(rst_n), .ce(ce), .din(din),
        .blank(blank), .in_seq(in_seq),
        .line_start(code_ok && !code_h),
        .y_data(y_data), .y_valid(y_valid),
        .c_data(c_data), .c_valid(c_valid), .c_is_cr(c_is_cr)
    );

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !code_ok |=> $stable({f_flag, v_flag, h_flag})); // R4
    AST_FIELD_FROM_EAV: assert property (@(posedge clk) disable iff (!rst_n)
        (code_ok && !code_h) |=> $stable(field)); // R7

endmodule

// File: tb/tb_vid_sync_decoder.sv
module tb_vid_sync_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b0;
    logic [7:0] din = 8'h00;
    logic       f_flag, v_flag, h_flag, blank, sav_strobe, field;
    logic [7:0] y_data, c_data;
    logic       y_valid, c_valid, c_is_cr;

    int nchk = 0;
    int nerr = 0;
    logic e_f = 0, e_v = 0, e_h = 0, e_blank = 1, e_field = 0;

    always #2.5 clk = ~clk;

    vid_sync_decoder dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .din(din),
        .f_flag(f_flag), .v_flag(v_flag), .h_flag(h_flag), .blank(blank),
        .sav_strobe(sav_strobe), .field(field),
        .y_data(y_data), .y_valid(y_valid),
        .c_data(c_data), .c_valid(c_valid), .c_is_cr(c_is_cr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] b, input logic e);
        @(negedge clk);
        din = b;
        ce  = e;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_flags(input string tag);
        chk({tag, " f_flag"}, f_flag, e_f);
        chk({tag, " v_flag"}, v_flag, e_v);
        chk({tag, " h_flag"}, h_flag, e_h);
        chk({tag, " blank"}, blank, e_blank);
        chk({tag, " field"}, field, e_field);
    endtask

    task automatic chk_quiet(input string tag);
        chk({tag, " y_valid"}, y_valid, 0);
        chk({tag, " c_valid"}, c_valid, 0);
        chk({tag, " sav_strobe"}, sav_strobe, 0);
    endtask

    task automatic send_code(input logic f, input logic v, input logic h,
                             input logic [3:0] prot);
        step(8'hFF, 1'b1); chk_flags("R4 pre1"); chk_quiet("R9 pre1");
        step(8'h00, 1'b1); chk_flags("R4 pre2"); chk_quiet("R9 pre2");
        step(8'h00, 1'b1); chk_flags("R4 pre3"); chk_quiet("R9 pre3");
        step({1'b1, f, v, h, prot}, 1'b1);
        e_f = f; e_v = v; e_h = h;
        if (h) begin
            e_blank = 1'b1;
            e_field = f;
        end else begin
            e_blank = v;
        end
        chk_flags("R2 R3 R5 R7 status");
        chk("R6 sav_strobe", sav_strobe, (!h && !v) ? 1 : 0);
        chk("R9 status not emitted", y_valid | c_valid, 0);
    endtask

    task automatic send_blank(input int n);
        for (int i = 0; i < n; i++) begin
            step((i % 2) ? 8'h10 : 8'h80, 1'b1);
            chk_flags("R5 blanking");
            chk_quiet("R9 blanking");
        end
    endtask

    task automatic send_active(input int n, input int seed, input logic gaps);
        for (int i = 0; i < n; i++) begin
            logic [7:0] val;
            if (gaps && (i % 3 == 1)) begin
                step(8'hFF, 1'b0);
                chk_quiet("R10 ce low");
                chk_flags("R10 ce low");
            end
            val = 8'(16 + ((i * 7 + seed * 13) % 200));
            step(val, 1'b1);
            chk("R6 strobe gone", sav_strobe, 0);
            chk("R8 c_valid", c_valid, (i % 2 == 0) ? 1 : 0);
            chk("R8 y_valid", y_valid, (i % 2 == 1) ? 1 : 0);
            if (i % 2 == 0) begin
                chk("R8 c_data", c_data, val);
                chk("R8 c_is_cr", c_is_cr, (i % 4 == 2) ? 1 : 0);
            end else begin
                chk("R8 y_data", y_data, val);
            end
        end
    endtask

    task automatic send_hidden(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            step(8'(16 + ((i * 11 + seed) % 200)), 1'b1);
            chk_quiet("R9 samples in blank");
            chk_flags("R5 samples in blank");
        end
    endtask

    initial begin
        repeat (3) step(8'h00, 1'b0);
        chk_flags("R1 reset");
        chk_quiet("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        step(8'h80, 1'b1);
        chk_flags("R1 after release");
        chk_quiet("R1 after release");

        for (int line = 0; line < 16; line++) begin
            logic f, v;
            logic [3:0] prot;
            f    = line[1];
            v    = line[2];
            prot = 4'((line * 5) % 16);
            send_code(f, v, 1'b1, prot);
            send_blank(4);
            // lines 8..15 start with a mismatched F to probe field (R7)
            send_code(line[3] ? !f : f, v, 1'b0, prot ^ 4'hA);
            if (!v) send_active(8 + line % 4, line, line[0]);
            else    send_hidden(6, line);
        end

        // R4 broken preambles during blanking
        send_code(1'b1, 1'b0, 1'b1, 4'h3);
        step(8'hFF, 1'b1); step(8'h00, 1'b1); step(8'h55, 1'b1);
        chk_flags("R4 break after one zero");
        step(8'hFF, 1'b1); step(8'h10, 1'b1);
        chk_flags("R4 break after ones");
        step(8'hFF, 1'b1); step(8'h00, 1'b1); step(8'h00, 1'b1);
        step(8'h40 | 8'h20 | 8'h05, 1'b1);
        chk_flags("R4 status bit7 clear");
        chk_quiet("R4 status bit7 clear");
        // R10 whole code with ce low
        step(8'hFF, 1'b0); step(8'h00, 1'b0); step(8'h00, 1'b0);
        step(8'hB0, 1'b0);
        chk_flags("R10 code ignored");
        chk_quiet("R10 code ignored");
        // R4 restart on repeated 0xFF
        step(8'hFF, 1'b1);
        send_code(1'b0, 1'b0, 1'b1, 4'hF);
        chk("R4 restart accepted h", h_flag, 1);
        // R3 protection nibble sweep on SAV codes
        for (int p = 0; p < 16; p++) begin
            send_code(1'b0, 1'b0, 1'b0, 4'(p));
            send_active(4, p, 1'b0);
            send_code(1'b0, 1'b0, 1'b1, 4'(15 - p));
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule